// File: doc/BRIEF.md
# Queued Lock Manager with Per-Slot Handoff Flags

This block arbitrates a single shared lock among a set of request ports and hands it over in strict arrival order. An acquire request is answered with a ticket slot drawn from a circular set of `N_SLOTS` positions. Each slot has one availability flag, and exactly one flag is set at any time. A port holding a ticket is granted the lock once the flag of its own slot is up. When the holder releases, its own flag is lowered and the flag of the following slot in circular order is raised, so the lock passes to the next ticket holder and to no other.

More ports than slots may be attached. The slot count therefore bounds how many tickets can be outstanding at once. Requests beyond that bound are turned away and reported. A release from a port that does not hold the lock is dropped and reported.

Top module: `qlock_unit`

## Requirements
- R1: After reset no grant, acknowledge or error output is asserted, the waiter count is 0, the flag of slot 0 is the one set and the next ticket to be issued is slot 0.
- R2: An accepted acquire raises `acq_ack` for that port for one cycle, one clock after the request. The port's `port_slot` field (bits [i*SW +: SW], SW = clog2(N_SLOTS)) then holds the issued slot. That slot is the issue counter modulo N_SLOTS, and the counter then advances.
- R3: Acquires that arrive in the same cycle are accepted in ascending port order, the lowest port first, and they receive consecutive slots.
- R4: A ticket holder's grant rises one clock after its slot's flag is set. If the flag is already set when the ticket is issued, the grant rises one clock after the acknowledge.
- R5: At most one grant is high at any time, and the lock passes between tickets in the order the slots were issued.
- R6: A release by the grant holder drops its grant one clock later and moves the set flag to the next slot mod N_SLOTS. The holder of that slot is granted one clock after that.
- R7: An acquire is refused when it would push the outstanding tickets above N_SLOTS. The refused port gets no acknowledge, and `ovf_err` pulses one clock later. Capacity freed by a release counts only from the following cycle.
- R8: A release from a port that is not the grant holder leaves grants and flags unchanged, and `rel_err` pulses one clock later.
- R9: An acquire from a port that already holds a ticket is ignored. It gets no acknowledge and raises no error.
- R10: `waiters` equals the number of outstanding tickets, the current holder included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | N_PORTS | Per-port acquire request, sampled each cycle |
| rel_req | input | N_PORTS | Per-port release request |
| acq_ack | output | N_PORTS | One-cycle pulse: acquire accepted |
| port_slot | output | N_PORTS*SW | Slot held by each port, valid while it holds a ticket |
| grant | output | N_PORTS | Port currently owns the lock |
| waiters | output | CW | Outstanding ticket count |
| ovf_err | output | 1 | Pulse: an acquire was refused for lack of slots |
| rel_err | output | 1 | Pulse: a release came from a non-holder |

## Verification
Slot issue and lock handoff can fall in the same cycle. A new ticket may take the very slot whose flag a simultaneous release is raising, and the capacity check then sees the count from before the release. The stimulus provokes this by driving several acquires together with a release from the holder, both in directed sequences and in random traffic. It judges the result against a cycle model in the bench that applies the release after computing grants and counts capacity from the pre-release ticket total.

// File: rtl/qlock_pkg.sv
package qlock_pkg;
  // circular slot arithmetic shared by allocator and flag array
  function automatic int slot_add(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction

  function automatic int ones(input logic [31:0] v);
    int c;
    c = 0;
    for (int k = 0; k < 32; k++) c += int'(v[k]);
    return c;
  endfunction
endpackage

// File: rtl/qlock_alloc.sv
module qlock_alloc
  import qlock_pkg::*;
#(
  parameter int N_PORTS = 6,
  parameter int N_SLOTS = 4,
  parameter int SW = 2,
  parameter int CW = 3
) (
  input  logic [N_PORTS-1:0] acq_req,
  input  logic [N_PORTS-1:0] busy,
  input  logic [SW-1:0]      tail,
  input  logic [CW-1:0]      free_cnt,
  output logic [N_PORTS-1:0] take,
  output logic [SW-1:0]      give_slot [N_PORTS],
  output logic [CW-1:0]      n_take,
  output logic               refused
);
  // fixed priority: lowest port index is served first
  always_comb begin
    int acc;
    acc = 0;
    take = '0;
    refused = 1'b0;
    for (int i = 0; i < N_PORTS; i++) begin
      give_slot[i] = SW'(slot_add(int'(tail), acc, N_SLOTS));
      if (acq_req[i] && !busy[i]) begin
        if (acc < int'(free_cnt)) begin
          take[i] = 1'b1;
          acc = acc + 1;
        end else begin
          refused = 1'b1;
        end
      end
    end
    n_take = CW'(acc);
  end
endmodule

// File: rtl/qlock_flags.sv
module qlock_flags
  import qlock_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int SW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_fire,
  input  logic [SW-1:0]      rel_slot,
  output logic [N_SLOTS-1:0] flags_q
);
  logic [SW-1:0] succ_slot;
  assign succ_slot = SW'(slot_add(int'(rel_slot), 1, N_SLOTS));

  for (genvar j = 0; j < N_SLOTS; j++) begin : g_flag
    logic clr_j, set_j;
    assign clr_j = rel_fire && (int'(rel_slot) == j);
    assign set_j = rel_fire && (int'(succ_slot) == j);
    always_ff @(posedge clk) begin
      if (!rst_n)     flags_q[j] <= (j == 0);
      else if (set_j) flags_q[j] <= 1'b1;
      else if (clr_j) flags_q[j] <= 1'b0;
    end
  end

  // R5: the lock token lives in exactly one flag
  a_r5_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(flags_q));
  // R6: after a release the released slot's flag is raised at its successor
  a_r6_flag_moves: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire |=> flags_q[SW'(slot_add(int'($past(rel_slot)), 1, N_SLOTS))]);
endmodule

// File: rtl/qlock_unit.sv
module qlock_unit
  import qlock_pkg::*;
#(
  parameter int N_PORTS = 6,
  parameter int N_SLOTS = 4,
  localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CW = $clog2(N_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PORTS-1:0]    acq_req,
  input  logic [N_PORTS-1:0]    rel_req,
  output logic [N_PORTS-1:0]    acq_ack,
  output logic [N_PORTS*SW-1:0] port_slot,
  output logic [N_PORTS-1:0]    grant,
  output logic [CW-1:0]         waiters,
  output logic                  ovf_err,
  output logic                  rel_err
);
  logic [N_PORTS-1:0] busy_q, grant_q, ack_q;
  logic [SW-1:0]      slot_q [N_PORTS];
  logic [SW-1:0]      tail_q;
  logic               ovf_q, relerr_q;

  // named internal events
  logic [N_PORTS-1:0] rel_ok, rel_bad, take;
  logic               rel_fire, refused;
  logic [SW-1:0]      rel_slot;
  logic [SW-1:0]      give_slot [N_PORTS];
  logic [CW-1:0]      n_take, free_cnt, busy_cnt;
  logic [N_SLOTS-1:0] flags;

  assign rel_ok   = rel_req & grant_q;
  assign rel_bad  = rel_req & ~grant_q;
  assign rel_fire = |rel_ok;
  assign busy_cnt = CW'(ones(32'(busy_q)));
  assign free_cnt = CW'(N_SLOTS - int'(busy_cnt));

  always_comb begin
    rel_slot = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (grant_q[i]) rel_slot = slot_q[i];
  end

  qlock_alloc #(.N_PORTS(N_PORTS), .N_SLOTS(N_SLOTS), .SW(SW), .CW(CW)) u_alloc (
    .acq_req(acq_req), .busy(busy_q), .tail(tail_q), .free_cnt(free_cnt),
    .take(take), .give_slot(give_slot), .n_take(n_take), .refused(refused)
  );

  qlock_flags #(.N_SLOTS(N_SLOTS), .SW(SW)) u_flags (
    .clk(clk), .rst_n(rst_n), .rel_fire(rel_fire), .rel_slot(rel_slot),
    .flags_q(flags)
  );

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[i]  <= 1'b0;
        grant_q[i] <= 1'b0;
        ack_q[i]   <= 1'b0;
        slot_q[i]  <= '0;
      end else begin
        ack_q[i]   <= take[i];
        grant_q[i] <= busy_q[i] && !rel_ok[i] && flags[slot_q[i]];
        if (take[i]) begin
          busy_q[i] <= 1'b1;
          slot_q[i] <= give_slot[i];
        end else if (rel_ok[i]) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
    assign port_slot[i*SW +: SW] = slot_q[i];

    // R4: a granted port's own flag is the one that is set
    a_r4_grant_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q[i] |-> flags[slot_q[i]]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q   <= '0;
      ovf_q    <= 1'b0;
      relerr_q <= 1'b0;
    end else begin
      tail_q   <= SW'(slot_add(int'(tail_q), int'(n_take), N_SLOTS));
      ovf_q    <= refused;
      relerr_q <= |rel_bad;
    end
  end

  assign acq_ack = ack_q;
  assign grant   = grant_q;
  assign waiters = busy_cnt;
  assign ovf_err = ovf_q;
  assign rel_err = relerr_q;

  // R5: mutual exclusion
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  // R10: ticket count never exceeds the slot count
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(waiters) <= N_SLOTS);
  // R8: an error pulse needs a release from a non-holder one cycle before
  a_r8_bad_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_req & ~grant_q) != '0);
  // R7: a refusal needs a pending request from an idle port one cycle before
  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(acq_req & ~busy_q) != '0);
endmodule

// File: tb/qlock_unit_test.sv
module qlock_unit_test;
  localparam int NP = 6;
  localparam int NS = 4;
  localparam int SW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] acq_req = '0, rel_req = '0;
  logic [NP-1:0] acq_ack, grant;
  logic [NP*SW-1:0] port_slot;
  logic [CW-1:0] waiters;
  logic ovf_err, rel_err;

  int errors = 0, checks = 0, cyc = 0;

  qlock_unit #(.N_PORTS(NP), .N_SLOTS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .acq_ack(acq_ack), .port_slot(port_slot), .grant(grant),
    .waiters(waiters), .ovf_err(ovf_err), .rel_err(rel_err)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [NP-1:0] m_busy, m_grant, m_ack;
  int m_slot [NP];
  int m_head, m_tail;
  logic m_ovf, m_relerr;

  function automatic int nxt(input int s, input int k);
    return (s + k) % NS;
  endfunction

  function automatic int cnt1(input logic [NP-1:0] v);
    int c = 0;
    for (int k = 0; k < NP; k++) if (v[k]) c++;
    return c;
  endfunction

  function automatic int pslot(input int p);
    return int'(port_slot[p*SW +: SW]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = '0; m_grant = '0; m_ack = '0; m_head = 0; m_tail = 0;
      m_ovf = 0; m_relerr = 0;
      for (int k = 0; k < NP; k++) m_slot[k] = 0;
    end else begin
      logic [NP-1:0] rok, gn, tk;
      int room, n;
      rok = rel_req & m_grant;
      m_relerr = |(rel_req & ~m_grant);
      room = NS - cnt1(m_busy);
      n = 0; tk = '0; m_ovf = 0;
      for (int k = 0; k < NP; k++) begin
        gn[k] = m_busy[k] && !rok[k] && (m_slot[k] == m_head);
        if (acq_req[k] && !m_busy[k]) begin
          if (n < room) begin tk[k] = 1; n++; end else m_ovf = 1;
        end
      end
      for (int k = 0; k < NP; k++)
        if (tk[k]) m_slot[k] = nxt(m_tail, cnt1(tk & ((NP'(1) << k) - 1)));
      if (|rok) m_head = nxt(m_head, 1);
      m_busy = (m_busy & ~rok) | tk;
      m_tail = nxt(m_tail, n);
      m_grant = gn; m_ack = tk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(grant == m_grant, "R5 grant vs model", int'(grant), int'(m_grant));
      chk(acq_ack == m_ack, "R2 ack vs model", int'(acq_ack), int'(m_ack));
      chk(int'(waiters) == cnt1(m_busy), "R10 waiters", int'(waiters), cnt1(m_busy));
      chk(ovf_err == m_ovf, "R7 overflow", int'(ovf_err), int'(m_ovf));
      chk(rel_err == m_relerr, "R8 bad release", int'(rel_err), int'(m_relerr));
      for (int k = 0; k < NP; k++)
        if (m_busy[k]) chk(pslot(k) == m_slot[k], "R3 slot", pslot(k), m_slot[k]);
    end
  end

  task automatic step(input logic [NP-1:0] a, input logic [NP-1:0] r);
    acq_req = a; rel_req = r;
    @(posedge clk);
    @(negedge clk);
    acq_req = '0; rel_req = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    // R1 reset state
    chk(grant == 0 && acq_ack == 0 && !ovf_err && !rel_err, "R1 outputs idle", int'(grant), 0);
    chk(waiters == 0, "R1 waiters", int'(waiters), 0);
    // R3: ports 3 and 1 together, lower port first
    step(6'b001010, '0);
    chk(acq_ack == 6'b001010, "R2 ack", int'(acq_ack), 10);
    chk(pslot(1) == 0 && pslot(3) == 1, "R3 consecutive slots", pslot(1)*10 + pslot(3), 1);
    chk(grant == 0, "R4 no grant yet", int'(grant), 0);
    step('0, '0);
    chk(grant == 6'b000010, "R4 grant after ack", int'(grant), 2);
    chk(waiters == 2, "R10 two tickets", int'(waiters), 2);
    // R8 bad release from port 3
    step('0, 6'b001000);
    chk(rel_err == 1 && grant == 6'b000010, "R8 ignored release", int'(grant), 2);
    // R9 repeat acquire from ticket holder
    step(6'b000010, '0);
    chk(acq_ack == 0 && !ovf_err && waiters == 2, "R9 repeat acquire", int'(acq_ack), 0);
    // R6 handoff
    step('0, 6'b000010);
    chk(grant == 0, "R6 holder dropped", int'(grant), 0);
    step('0, '0);
    chk(grant == 6'b001000, "R6 next granted", int'(grant), 8);
    // R7: one ticket out, four idle ports ask, three slots free
    step(6'b110101, '0);
    chk(acq_ack == 6'b010101, "R7 accepted set", int'(acq_ack), 21);
    chk(ovf_err == 1, "R7 overflow pulse", int'(ovf_err), 1);
    chk(pslot(0) == 2 && pslot(2) == 3 && pslot(4) == 0, "R2 slot wrap",
        pslot(0)*100 + pslot(2)*10 + pslot(4), 230);
    // R5 FIFO: holder 3 releases while port 5 asks (full until next cycle)
    step(6'b100000, 6'b001000);
    chk(ovf_err == 1 && acq_ack == 0, "R7 freed capacity not yet usable", int'(acq_ack), 0);
    step('0, '0);
    chk(grant == 6'b000001, "R5 FIFO order port0", int'(grant), 1);
    // random traffic against model
    for (int t = 0; t < 3000; t++) begin
      logic [NP-1:0] a, r;
      a = NP'($urandom) & NP'($urandom);
      r = ($urandom % 10 < 6) ? m_grant : '0;
      if ($urandom % 10 == 0) r = r | (NP'(1) << ($urandom % NP));
      step(a, r);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule